// File: doc/BRIEF.md
# Depth Merge Chain

This block resolves per-pixel visibility by handing each pixel down a line of identical stages. Each stage owns one primitive: a colour, a depth and an inclusive screen rectangle standing in for its coverage. A pixel enters the head of the chain with a background colour and the smallest depth. At each stage, the stage's own colour and depth replace the carried pair when the primitive covers the pixel and is strictly nearer (larger depth). The value that leaves the tail is the visible colour. No depth buffer memory is needed.

Primitives are written into stages through a shared set of load inputs, with a one-hot select per stage. The pixel stream is registered at every stage, so one pixel per cycle is accepted and each result appears a fixed number of cycles later. A scene with more primitives than stages has to be rendered in several passes, and that work lies outside this block.

Top module: `depth_merge_chain`

## Requirements
- R1: While reset is asserted and after it is released, `res_vld` is 0, `res_rgb`, `res_z`, `res_x` and `res_y` are 0, and every stage is empty.
- R2: A pixel presented with `pix_vld` high at a clock edge comes out with `res_vld` high exactly NUM_STAGES edges later. Its `res_x` and `res_y` equal its input coordinates. One pixel is accepted on every cycle.
- R3: The head of the chain carries `bg_rgb` with depth 0. A pixel that no loaded primitive covers comes out as `bg_rgb` with `res_z` 0.
- R4: A loaded stage whose rectangle covers the pixel, and whose depth is strictly greater than the carried depth, replaces the carried colour and depth with its own.
- R5: A covering stage whose depth is lower than the carried depth leaves the carried colour and depth unchanged.
- R6: On equal depths the carried pair is kept, so the stage nearer the head wins a tie.
- R7: Coverage is inclusive: a stage covers pixel (x,y) when x0 <= x <= x1 and y0 <= y <= y1. A pixel one step outside any edge is not covered.
- R8: With `ld_sel[i]` high at an edge, stage i takes the load colour, depth and rectangle, and `ld_live` sets whether it is loaded. The new contents apply to pixels that enter that stage from the next cycle on. A stage loaded with `ld_live` 0 passes every pixel through.
- R9: A cycle with `pix_vld` low gives `res_vld` low NUM_STAGES cycles later. `res_rgb`, `res_z`, `res_x` and `res_y` keep their last valid values.
- R10: A primitive with depth 0 never replaces the background, even where it covers the pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_sel | input | NUM_STAGES | One-hot stage select for a load |
| ld_live | input | 1 | 1 loads a primitive, 0 empties the stage |
| ld_rgb | input | 24 | Primitive colour |
| ld_z | input | 16 | Primitive depth, larger is nearer |
| ld_x0 | input | 8 | Rectangle left edge, inclusive |
| ld_x1 | input | 8 | Rectangle right edge, inclusive |
| ld_y0 | input | 8 | Rectangle top edge, inclusive |
| ld_y1 | input | 8 | Rectangle bottom edge, inclusive |
| bg_rgb | input | 24 | Background colour seeded at the head |
| pix_vld | input | 1 | Pixel present this cycle |
| pix_x | input | 8 | Pixel column |
| pix_y | input | 8 | Pixel row |
| res_vld | output | 1 | Resolved pixel present |
| res_x | output | 8 | Resolved pixel column |
| res_y | output | 8 | Resolved pixel row |
| res_rgb | output | 24 | Visible colour |
| res_z | output | 16 | Visible depth |

## Verification
Four overlapping rectangles are loaded at different depths, and a stream of back-to-back pixels is then run through them. The pixels fall where a nearer stage must take over, where a farther later stage must leave the carried value alone, where two stages tie, and where nothing covers, so that each comparison outcome gives a different colour. Further pixels sit on each rectangle edge and one step past it, which separates inclusive from exclusive coverage. Directed cases then measure the exact output latency, show that the output holds through idle cycles, empty and reload stages between pixels, and load a depth-0 primitive that must lose to the background.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int COORD_W = 8;
  localparam int Z_W     = 16;
  localparam int RGB_W   = 24;

  typedef logic [COORD_W-1:0] coord_t;
  typedef logic [Z_W-1:0]     z_t;
  typedef logic [RGB_W-1:0]   rgb_t;

  // pixel travelling down the chain
  typedef struct packed {
    coord_t x;
    coord_t y;
    rgb_t   rgb;
    z_t     z;
  } frag_t;

  // primitive held by one stage
  typedef struct packed {
    logic   live;
    rgb_t   rgb;
    z_t     z;
    coord_t x0;
    coord_t x1;
    coord_t y0;
    coord_t y1;
  } prim_t;
endpackage

// File: rtl/dmc_rst_sync.sv
module dmc_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/dmc_cover.sv
module dmc_cover
  import dmc_pkg::*;
(
  input  logic   live,
  input  coord_t px,
  input  coord_t py,
  input  coord_t x0,
  input  coord_t x1,
  input  coord_t y0,
  input  coord_t y1,
  output logic   hit
);
  logic in_x;
  logic in_y;

  always_comb begin
    in_x = (px >= x0) && (px <= x1);
    in_y = (py >= y0) && (py <= y1);
    hit  = live && in_x && in_y;
  end
endmodule

// File: rtl/dmc_stage.sv
module dmc_stage
  import dmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_en,
  input  prim_t ld_prim,
  input  logic  in_vld,
  input  frag_t in_frag,
  output logic  out_vld,
  output frag_t out_frag,
  output logic  own_live,
  output z_t    own_z,
  output rgb_t  own_rgb
);
  prim_t prim_q, prim_d;
  frag_t frag_q, frag_d, pick;
  logic  vld_q, vld_d;
  logic  covered, own_wins;

  dmc_cover u_cover (
    .live (prim_q.live),
    .px   (in_frag.x),
    .py   (in_frag.y),
    .x0   (prim_q.x0),
    .x1   (prim_q.x1),
    .y0   (prim_q.y0),
    .y1   (prim_q.y1),
    .hit  (covered)
  );

  // strict compare: on equal depth the carried value stays
  always_comb begin
    own_wins = covered && (prim_q.z > in_frag.z);
    pick     = in_frag;
    if (own_wins) begin
      pick.rgb = prim_q.rgb;
      pick.z   = prim_q.z;
    end
  end

  always_comb begin
    prim_d = ld_en  ? ld_prim : prim_q;
    frag_d = in_vld ? pick    : frag_q;
    vld_d  = in_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_q <= '0;
      frag_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      prim_q <= prim_d;
      frag_q <= frag_d;
      vld_q  <= vld_d;
    end
  end

  assign out_vld  = vld_q;
  assign out_frag = frag_q;
  assign own_live = prim_q.live;
  assign own_z    = prim_q.z;
  assign own_rgb  = prim_q.rgb;
endmodule

// File: rtl/depth_merge_chain.sv
module depth_merge_chain
  import dmc_pkg::*;
#(
  parameter int NUM_STAGES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STAGES-1:0] ld_sel,
  input  logic                  ld_live,
  input  logic [RGB_W-1:0]      ld_rgb,
  input  logic [Z_W-1:0]        ld_z,
  input  logic [COORD_W-1:0]    ld_x0,
  input  logic [COORD_W-1:0]    ld_x1,
  input  logic [COORD_W-1:0]    ld_y0,
  input  logic [COORD_W-1:0]    ld_y1,
  input  logic [RGB_W-1:0]      bg_rgb,
  input  logic                  pix_vld,
  input  logic [COORD_W-1:0]    pix_x,
  input  logic [COORD_W-1:0]    pix_y,
  output logic                  res_vld,
  output logic [COORD_W-1:0]    res_x,
  output logic [COORD_W-1:0]    res_y,
  output logic [RGB_W-1:0]      res_rgb,
  output logic [Z_W-1:0]        res_z
);
  localparam int LAST = NUM_STAGES;

  logic                    rst_n_s;
  prim_t                   ld_prim;
  logic  [NUM_STAGES:0]    lane_vld;
  frag_t [NUM_STAGES:0]    lane_frag;
  logic  [NUM_STAGES-1:0]  prim_live;
  z_t    [NUM_STAGES-1:0]  prim_z;
  rgb_t  [NUM_STAGES-1:0]  prim_rgb;

  dmc_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  always_comb begin
    ld_prim.live = ld_live;
    ld_prim.rgb  = ld_rgb;
    ld_prim.z    = ld_z;
    ld_prim.x0   = ld_x0;
    ld_prim.x1   = ld_x1;
    ld_prim.y0   = ld_y0;
    ld_prim.y1   = ld_y1;
  end

  // head of chain: background at the farthest depth
  always_comb begin
    lane_vld[0]       = pix_vld;
    lane_frag[0].x    = pix_x;
    lane_frag[0].y    = pix_y;
    lane_frag[0].rgb  = bg_rgb;
    lane_frag[0].z    = '0;
  end

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    dmc_stage u_stage (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .ld_en    (ld_sel[g]),
      .ld_prim  (ld_prim),
      .in_vld   (lane_vld[g]),
      .in_frag  (lane_frag[g]),
      .out_vld  (lane_vld[g+1]),
      .out_frag (lane_frag[g+1]),
      .own_live (prim_live[g]),
      .own_z    (prim_z[g]),
      .own_rgb  (prim_rgb[g])
    );
  end

  assign res_vld = lane_vld[LAST];
  assign res_x   = lane_frag[LAST].x;
  assign res_y   = lane_frag[LAST].y;
  assign res_rgb = lane_frag[LAST].rgb;
  assign res_z   = lane_frag[LAST].z;
endmodule

// File: rtl/dmc_chk.sv
module dmc_chk
  import dmc_pkg::*;
#(
  parameter int K = 4
) (
  input logic           clk,
  input logic           rst_n_s,
  input logic  [K:0]    lane_vld,
  input frag_t [K:0]    lane_frag,
  input logic  [K-1:0]  prim_live,
  input z_t    [K-1:0]  prim_z,
  input rgb_t  [K-1:0]  prim_rgb
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  // R1: all stages empty and output idle while held in reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n_s |-> (lane_vld[K] == 1'b0) && (prim_live == '0));

  for (genvar gi = 0; gi < K; gi++) begin : g_chk
    assert_vld_step_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
      armed |-> lane_vld[gi+1] == $past(lane_vld[gi]));

    assert_coord_pass_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
      (armed && $past(lane_vld[gi])) |->
        (lane_frag[gi+1].x == $past(lane_frag[gi].x)) &&
        (lane_frag[gi+1].y == $past(lane_frag[gi].y)));

    assert_depth_rise_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
      (armed && $past(lane_vld[gi])) |->
        lane_frag[gi+1].z >= $past(lane_frag[gi].z));

    assert_take_own_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
      (armed && $past(lane_vld[gi]) &&
       (lane_frag[gi+1].z != $past(lane_frag[gi].z))) |->
        (lane_frag[gi+1].z == $past(prim_z[gi])) &&
        (lane_frag[gi+1].rgb == $past(prim_rgb[gi])));

    assert_tie_keep_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
      (armed && $past(lane_vld[gi]) &&
       ($past(prim_z[gi]) == $past(lane_frag[gi].z))) |->
        lane_frag[gi+1].rgb == $past(lane_frag[gi].rgb));

    assert_empty_pass_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
      (armed && $past(lane_vld[gi]) && !$past(prim_live[gi])) |->
        lane_frag[gi+1] == $past(lane_frag[gi]));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
      (armed && !$past(lane_vld[gi])) |-> $stable(lane_frag[gi+1]));
  end
endmodule

bind depth_merge_chain dmc_chk #(.K(NUM_STAGES)) u_dmc_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .lane_vld  (lane_vld),
  .lane_frag (lane_frag),
  .prim_live (prim_live),
  .prim_z    (prim_z),
  .prim_rgb  (prim_rgb)
);

// File: tb/test_depth_merge_chain.sv
module test_depth_merge_chain;
  localparam int CLK_PERIOD = 10;
  localparam int K          = 4;
  localparam int NV         = 12;
  localparam logic [23:0] BG = 24'h101010;

  typedef struct packed {
    logic [7:0]  x;
    logic [7:0]  y;
    logic [23:0] rgb;
    logic [15:0] z;
    logic [7:0]  req;
  } vec_t;

  // Scene: s0 AA0000 z100 [0..9]x[0..9], s1 00BB00 z200 [5..14]^2,
  //        s2 0000CC z200 [12..20]x[10..20], s3 777777 z50 [0..30]^2
  localparam vec_t VECS [NV] = '{
    '{8'd2,  8'd2,  24'hAA0000, 16'd100, 8'd5},  // R5: s3 farther than s0
    '{8'd7,  8'd7,  24'h00BB00, 16'd200, 8'd4},  // R4: s1 nearer than s0
    '{8'd13, 8'd12, 24'h00BB00, 16'd200, 8'd6},  // R6: s1 and s2 tie
    '{8'd18, 8'd18, 24'h0000CC, 16'd200, 8'd4},  // R4: s2 alone
    '{8'd25, 8'd25, 24'h777777, 16'd50,  8'd4},  // R4: s3 over background
    '{8'd40, 8'd40, BG,         16'd0,   8'd3},  // R3: nothing covers
    '{8'd4,  8'd9,  24'hAA0000, 16'd100, 8'd7},  // R7: one left of s1
    '{8'd10, 8'd2,  24'h777777, 16'd50,  8'd7},  // R7: one right of s0
    '{8'd31, 8'd0,  BG,         16'd0,   8'd7},  // R7: one right of s3
    '{8'd30, 8'd30, 24'h777777, 16'd50,  8'd7},  // R7: s3 far corner
    '{8'd9,  8'd9,  24'h00BB00, 16'd200, 8'd4},  // R4: s0 corner, s1 wins
    '{8'd0,  8'd0,  24'hAA0000, 16'd100, 8'd7}   // R7: s0 near corner
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [K-1:0] ld_sel;
  logic         ld_live;
  logic [23:0]  ld_rgb;
  logic [15:0]  ld_z;
  logic [7:0]   ld_x0, ld_x1, ld_y0, ld_y1;
  logic [23:0]  bg_rgb;
  logic         pix_vld;
  logic [7:0]   pix_x, pix_y;
  logic         res_vld;
  logic [7:0]   res_x, res_y;
  logic [23:0]  res_rgb;
  logic [15:0]  res_z;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  depth_merge_chain #(.NUM_STAGES(K)) i_depth_merge_chain (
    .clk(clk), .rst_n(rst_n), .ld_sel(ld_sel), .ld_live(ld_live),
    .ld_rgb(ld_rgb), .ld_z(ld_z), .ld_x0(ld_x0), .ld_x1(ld_x1),
    .ld_y0(ld_y0), .ld_y1(ld_y1), .bg_rgb(bg_rgb), .pix_vld(pix_vld),
    .pix_x(pix_x), .pix_y(pix_y), .res_vld(res_vld), .res_x(res_x),
    .res_y(res_y), .res_rgb(res_rgb), .res_z(res_z)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic live, input logic [23:0] rgb,
                      input logic [15:0] z, input logic [7:0] x0, x1, y0, y1);
    @(negedge clk);
    ld_sel = '0;
    ld_sel[idx] = 1'b1;
    ld_live = live; ld_rgb = rgb; ld_z = z;
    ld_x0 = x0; ld_x1 = x1; ld_y0 = y0; ld_y1 = y1;
    @(negedge clk);
    ld_sel = '0;
  endtask

  // drive one pixel, return at the negedge where it is due at the output
  task automatic one_pixel(input logic [7:0] x, input logic [7:0] y);
    @(negedge clk);
    pix_vld = 1'b1; pix_x = x; pix_y = y;
    @(negedge clk);
    pix_vld = 1'b0;
    repeat (K-1) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ld_sel = '0; ld_live = 1'b0; ld_rgb = '0; ld_z = '0;
    ld_x0 = '0; ld_x1 = '0; ld_y0 = '0; ld_y1 = '0;
    bg_rgb = BG; pix_vld = 1'b0; pix_x = '0; pix_y = '0;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    check(res_vld == 1'b0 && res_rgb == '0 && res_z == '0, "R1",
          {res_vld, res_rgb, res_z}, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(res_vld == 1'b0 && res_x == '0 && res_y == '0 && res_rgb == '0,
          "R1", {res_vld, res_x, res_y, res_rgb}, 64'h0);
    // R1: empty stages after reset, a pixel comes out as background
    one_pixel(8'd5, 8'd5);
    check({res_rgb, res_z} == {BG, 16'd0}, "R1", {res_rgb, res_z}, {BG, 16'd0});

    load(0, 1'b1, 24'hAA0000, 16'd100, 8'd0,  8'd9,  8'd0,  8'd9);
    load(1, 1'b1, 24'h00BB00, 16'd200, 8'd5,  8'd14, 8'd5,  8'd14);
    load(2, 1'b1, 24'h0000CC, 16'd200, 8'd12, 8'd20, 8'd10, 8'd20);
    load(3, 1'b1, 24'h777777, 16'd50,  8'd0,  8'd30, 8'd0,  8'd30);

    // back-to-back stream; each vector is checked K cycles after entry
    for (int t = 0; t < NV + K; t++) begin
      @(negedge clk);
      if (t >= K) begin
        vec_t e;
        e = VECS[t-K];
        check(res_vld && res_x == e.x && res_y == e.y &&
              res_rgb == e.rgb && res_z == e.z,
              $sformatf("R%0d (vector %0d)", e.req, t-K),
              {res_vld, res_x, res_y, res_rgb, res_z},
              {1'b1, e.x, e.y, e.rgb, e.z});
      end
      if (t < NV) begin
        pix_vld = 1'b1; pix_x = VECS[t].x; pix_y = VECS[t].y;
      end else begin
        pix_vld = 1'b0;
      end
    end

    // R9: idle cycles keep the last result (vector 11)
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(!res_vld && res_rgb == 24'hAA0000 && res_z == 16'd100 &&
            res_x == 8'd0 && res_y == 8'd0, "R9",
            {res_vld, res_rgb, res_z}, {1'b0, 24'hAA0000, 16'd100});
    end

    // R2: exact latency of K cycles
    @(negedge clk);
    pix_vld = 1'b1; pix_x = 8'd25; pix_y = 8'd25;
    for (int c = 1; c <= K; c++) begin
      @(negedge clk);
      pix_vld = 1'b0;
      check(res_vld == (c == K), $sformatf("R2 (cycle %0d)", c),
            {63'd0, res_vld}, {63'd0, (c == K)});
    end
    check(res_rgb == 24'h777777 && res_x == 8'd25, "R2",
          {res_rgb, res_x}, {24'h777777, 8'd25});

    // R8: emptying s1 lets s0 show at (7,7)
    load(1, 1'b0, 24'h00BB00, 16'd200, 8'd5, 8'd14, 8'd5, 8'd14);
    one_pixel(8'd7, 8'd7);
    check({res_rgb, res_z} == {24'hAA0000, 16'd100}, "R8",
          {res_rgb, res_z}, {24'hAA0000, 16'd100});

    // R8: reload s2 nearer over the full screen
    load(2, 1'b1, 24'h00FF00, 16'd300, 8'd0, 8'd255, 8'd0, 8'd255);
    one_pixel(8'd7, 8'd7);
    check({res_rgb, res_z} == {24'h00FF00, 16'd300}, "R8",
          {res_rgb, res_z}, {24'h00FF00, 16'd300});

    // R10: depth-0 primitive cannot beat the background
    load(2, 1'b0, 24'h0, 16'd0, 8'd0, 8'd0, 8'd0, 8'd0);
    load(3, 1'b1, 24'h123456, 16'd0, 8'd0, 8'd255, 8'd0, 8'd255);
    one_pixel(8'd40, 8'd40);
    check({res_rgb, res_z} == {BG, 16'd0}, "R10",
          {res_rgb, res_z}, {BG, 16'd0});

    finish_run();
  end
endmodule